// File: doc/BRIEF.md
# Delay-Locked Loop Lock Controller

This block is the digital half of a delay-locked loop. An analog delay line of equal stages sits outside the block. Once the loop has locked, the total delay of that line equals one reference clock period, so the taps fall evenly across the period. A phase arbiter compares each reference edge with the output of the last tap and reports one of three results. The result is lag when the line output comes late, lead when it comes early, and neither when the two are aligned. The controller turns these reports into a delay-control code for the analog line. It never produces a delay itself; it only sets the control value.

The reports are filtered before they move the code. The code takes one step only after a run of agreeing reports in the same direction. Scattered or alternating reports therefore leave the delay alone. A lock detector watches the same report stream and raises a flag after a long run of aligned results. It drops the flag after a shorter run of misaligned ones. A report where lag and lead are both asserted at once is illegal and is discarded.

Top module: `dll_lock_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it rises, `delayCode` is 128 (mid-scale) and `lockFlag` is 0.
- R2: A lag report (`arbLag`=1, `arbLead`=0) asks for a shorter delay. A larger code means a longer delay, so on the second consecutive lag report (FILT_LEN=2) the code falls by one. The lag run then restarts from zero.
- R3: A lead report (`arbLag`=0, `arbLead`=1) asks for a longer delay. On the second consecutive lead report the code rises by one, and the lead run restarts.
- R4: An aligned report (both inputs 0) leaves the code unchanged and clears any partial lag or lead run.
- R5: An illegal report (both inputs 1) changes nothing: not the code, not the flag, and not any run count. A run that the illegal report interrupts continues afterwards as if the report had not occurred.
- R6: The code saturates at 0 and at 255, with no wraparound.
- R7: `lockFlag` rises on the 16th consecutive aligned report, in the cycle after that report is sampled.
- R8: `lockFlag` falls on the 4th consecutive misaligned report; lag and lead may be mixed within that run. An aligned report restarts the count.
- R9: A lag report followed directly by a lead report (or a lead followed by a lag) restarts the run, so a strictly alternating pattern never moves the code.
- R10: The code changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock; one arbiter report per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| arbLag | input | 1 | Arbiter reports that the delay-line output is late |
| arbLead | input | 1 | Arbiter reports that the delay-line output is early |
| delayCode | output | 8 | Delay-control code; a larger value means a longer delay |
| lockFlag | output | 1 | High while the loop is considered locked |

## Verification
Steady runs of lag and of lead tell the down path from the up path and show the two-report filter stepping. An alternating lag/lead pattern separates a filtered update from a plain up/down counter. Illegal reports placed in the middle of a run, and again while locked, show that they hold every piece of state. Long one-sided runs drive the code into both rails. A closed loop with a behavioural delay-line model then checks that the code settles on the matching value and that the flag rises.

// File: rtl/dll_lock_pkg.sv
package dll_lock_pkg;

  // Decoded arbiter report for one reference edge
  typedef enum logic [1:0] {
    DEC_OK   = 2'd0,
    DEC_LAG  = 2'd1,
    DEC_LEAD = 2'd2,
    DEC_BAD  = 2'd3
  } arbDec_t;

  // Strobes from the control side to the code datapath
  typedef struct packed {
    logic stepUp;
    logic stepDn;
  } codeStrobes_t;

endpackage

// File: rtl/dll_phase_filter.sv
module dll_phase_filter
  import dll_lock_pkg::*;
#(
  parameter int FILT_LEN = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         arbLag,
  input  logic         arbLead,
  output arbDec_t      decision,
  output codeStrobes_t strobes
);

  localparam int RUN_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

  logic [RUN_W-1:0] lagRun;
  logic [RUN_W-1:0] leadRun;

  // Report decode
  always_comb begin
    unique case ({arbLag, arbLead})
      2'b00:   decision = DEC_OK;
      2'b10:   decision = DEC_LAG;
      2'b01:   decision = DEC_LEAD;
      default: decision = DEC_BAD;
    endcase
  end

  // A step fires when the run reaches its last slot
  always_comb begin
    strobes.stepDn = (decision == DEC_LAG)  && (lagRun  == RUN_LAST);
    strobes.stepUp = (decision == DEC_LEAD) && (leadRun == RUN_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lagRun  <= '0;
      leadRun <= '0;
    end else begin
      unique case (decision)
        DEC_LAG: begin
          leadRun <= '0;
          if (lagRun == RUN_LAST) lagRun <= '0;
          else                    lagRun <= lagRun + 1'b1;
        end
        DEC_LEAD: begin
          lagRun <= '0;
          if (leadRun == RUN_LAST) leadRun <= '0;
          else                     leadRun <= leadRun + 1'b1;
        end
        DEC_OK: begin
          lagRun  <= '0;
          leadRun <= '0;
        end
        default: begin
          lagRun  <= lagRun;
          leadRun <= leadRun;
        end
      endcase
    end
  end

endmodule

// File: rtl/dll_lock_detect.sv
module dll_lock_detect
  import dll_lock_pkg::*;
#(
  parameter int LOCK_SET = 16,
  parameter int LOCK_CLR = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  arbDec_t decision,
  output logic    locked
);

  localparam int OK_W  = (LOCK_SET < 2) ? 1 : $clog2(LOCK_SET);
  localparam int ERR_W = (LOCK_CLR < 2) ? 1 : $clog2(LOCK_CLR);
  localparam logic [OK_W-1:0]  OK_LAST  = OK_W'(LOCK_SET - 1);
  localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(LOCK_CLR - 1);

  logic [OK_W-1:0]  okRun;
  logic [ERR_W-1:0] errRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      okRun  <= '0;
      errRun <= '0;
      locked <= 1'b0;
    end else begin
      unique case (decision)
        DEC_OK: begin
          errRun <= '0;
          if (okRun == OK_LAST) locked <= 1'b1;
          else                  okRun  <= okRun + 1'b1;
        end
        DEC_LAG, DEC_LEAD: begin
          okRun <= '0;
          if (errRun == ERR_LAST) locked <= 1'b0;
          else                    errRun <= errRun + 1'b1;
        end
        default: begin
          okRun  <= okRun;
          errRun <= errRun;
          locked <= locked;
        end
      endcase
    end
  end

endmodule

// File: rtl/dll_code_path.sv
module dll_code_path
  import dll_lock_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  codeStrobes_t      strobes,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [CODE_W-1:0] codeNext;

  always_comb begin
    codeNext = code;
    if (strobes.stepUp && (code != CODE_MAX))
      codeNext = code + 1'b1;
    else if (strobes.stepDn && (code != '0))
      codeNext = code - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) code <= CODE_MID;
    else       code <= codeNext;
  end

endmodule

// File: rtl/dll_lock_ctrl.sv
module dll_lock_ctrl
  import dll_lock_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int FILT_LEN = 2,
  parameter int LOCK_SET = 16,
  parameter int LOCK_CLR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              arbLag,
  input  logic              arbLead,
  output logic [CODE_W-1:0] delayCode,
  output logic              lockFlag
);

  arbDec_t      decision;
  codeStrobes_t strobes;

  dll_phase_filter #(.FILT_LEN(FILT_LEN)) i_filter (
    .clk      (clk),
    .rstN     (rstN),
    .arbLag   (arbLag),
    .arbLead  (arbLead),
    .decision (decision),
    .strobes  (strobes)
  );

  dll_lock_detect #(.LOCK_SET(LOCK_SET), .LOCK_CLR(LOCK_CLR)) i_lock (
    .clk      (clk),
    .rstN     (rstN),
    .decision (decision),
    .locked   (lockFlag)
  );

  dll_code_path #(.CODE_W(CODE_W)) i_code (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .code    (delayCode)
  );

endmodule

// File: rtl/dll_lock_ctrl_chk.sv
module dll_lock_ctrl_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              arbLag,
  input logic              arbLead,
  input logic [CODE_W-1:0] delayCode,
  input logic              lockFlag
);

  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic started;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  // R4
  assert_ok_holds_R4: assert property (@(posedge clk) disable iff (!rstN || !started)
    (!arbLag && !arbLead) |=> $stable(delayCode));

  // R5
  assert_bad_holds_R5: assert property (@(posedge clk) disable iff (!rstN || !started)
    (arbLag && arbLead) |=> ($stable(delayCode) && $stable(lockFlag)));

  // R2
  assert_lag_no_rise_R2: assert property (@(posedge clk) disable iff (!rstN || !started)
    (arbLag && !arbLead) |=> (delayCode <= $past(delayCode)));

  // R3
  assert_lead_no_fall_R3: assert property (@(posedge clk) disable iff (!rstN || !started)
    (arbLead && !arbLag) |=> (delayCode >= $past(delayCode)));

  // R6
  assert_floor_R6: assert property (@(posedge clk) disable iff (!rstN || !started)
    ((delayCode == '0) && arbLag) |=> (delayCode == '0));

  assert_ceiling_R6: assert property (@(posedge clk) disable iff (!rstN || !started)
    ((delayCode == CODE_MAX) && arbLead) |=> (delayCode == CODE_MAX));

  // R10
  assert_single_step_R10: assert property (@(posedge clk) disable iff (!rstN || !started)
    !$stable(delayCode) |->
      ((delayCode == $past(delayCode) + 1'b1) || (delayCode == $past(delayCode) - 1'b1)));

  // R7
  assert_lock_rise_R7: assert property (@(posedge clk) disable iff (!rstN || !started)
    $rose(lockFlag) |-> $past(!arbLag && !arbLead));

  // R8
  assert_lock_fall_R8: assert property (@(posedge clk) disable iff (!rstN || !started)
    $fell(lockFlag) |-> $past(arbLag ^ arbLead));

endmodule

bind dll_lock_ctrl dll_lock_ctrl_chk #(.CODE_W(CODE_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .arbLag    (arbLag),
  .arbLead   (arbLead),
  .delayCode (delayCode),
  .lockFlag  (lockFlag)
);

// File: tb/test_dll_lock_ctrl.sv
`timescale 1ns/1ps
module test_dll_lock_ctrl;

  localparam int FILT = 2;
  localparam int LSET = 16;
  localparam int LCLR = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       arbLag = 1'b0;
  logic       arbLead = 1'b0;
  logic [7:0] delayCode;
  logic       lockFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dll_lock_ctrl i_dll_lock_ctrl (
    .clk(clk), .rstN(rstN), .arbLag(arbLag), .arbLead(arbLead),
    .delayCode(delayCode), .lockFlag(lockFlag)
  );

  typedef struct {
    int    code;
    bit    lock;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  // Reference state kept from the requirements
  int mCode, mLagRun, mLeadRun, mOkRun, mErrRun;
  bit mLock;

  task automatic modelReset();
    mCode = 128; mLock = 0;
    mLagRun = 0; mLeadRun = 0; mOkRun = 0; mErrRun = 0;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: apply one report, advance the model, queue the expected outcome
  task automatic step(input bit lg, input bit ld, input string tag);
    expItem_t it;
    @(negedge clk);
    arbLag = lg; arbLead = ld;
    if (lg && !ld) begin
      mLeadRun = 0; mLagRun++;
      if (mLagRun == FILT) begin mLagRun = 0; if (mCode > 0) mCode--; end
      mOkRun = 0; mErrRun++;
      if (mErrRun >= LCLR) begin mErrRun = LCLR; mLock = 0; end
    end else if (ld && !lg) begin
      mLagRun = 0; mLeadRun++;
      if (mLeadRun == FILT) begin mLeadRun = 0; if (mCode < 255) mCode++; end
      mOkRun = 0; mErrRun++;
      if (mErrRun >= LCLR) begin mErrRun = LCLR; mLock = 0; end
    end else if (!lg && !ld) begin
      mLagRun = 0; mLeadRun = 0;
      mErrRun = 0; mOkRun++;
      if (mOkRun >= LSET) begin mOkRun = LSET; mLock = 1; end
    end
    it.code = mCode; it.lock = mLock; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare each result just after the edge that produced it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(delayCode == it.code[7:0], {it.tag, " code"}, delayCode, it.code);
        check(lockFlag == it.lock, {it.tag, " lock"}, lockFlag, it.lock);
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    arbLag = 0; arbLead = 0; rstN = 0;
    modelReset();
    @(negedge clk); @(negedge clk);
    rstN = 1;
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    modelReset();
    // R1: reset state, while held and just after release
    @(negedge clk);
    check(delayCode == 8'd128, "R1 code in reset", delayCode, 128);
    check(lockFlag == 1'b0, "R1 lock in reset", lockFlag, 0);
    doReset();
    @(posedge clk); #2;
    check(delayCode == 8'd128, "R1 code after release", delayCode, 128);
    check(lockFlag == 1'b0, "R1 lock after release", lockFlag, 0);

    // R2: steady lag lowers the code every second report
    for (int i = 0; i < 6; i++) step(1, 0, "R2");
    // R4: aligned reports hold the code, partial run is cleared
    step(1, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, "R4");
    step(1, 0, "R4");
    // R3: steady lead raises the code
    for (int i = 0; i < 8; i++) step(0, 1, "R3");
    // R9: alternating reports never move the code
    for (int i = 0; i < 10; i++) step(i % 2 == 0, i % 2 == 1, "R9");
    // R5: illegal report inside a run keeps the partial run
    step(0, 0, "R5");
    step(1, 0, "R5");
    step(1, 1, "R5");
    step(1, 0, "R5");
    step(0, 1, "R5");
    step(1, 1, "R5");
    step(0, 1, "R5");
    // R7: sixteen aligned reports raise the flag
    for (int i = 0; i < 20; i++) step(0, 0, "R7");
    // R5: illegal while locked keeps the flag
    for (int i = 0; i < 3; i++) step(1, 1, "R5");
    // R8: misaligned run broken by aligned, then four in a row
    step(1, 0, "R8"); step(0, 1, "R8"); step(1, 0, "R8");
    step(0, 0, "R8");
    step(1, 0, "R8"); step(0, 1, "R8"); step(1, 0, "R8"); step(0, 1, "R8");
    step(0, 1, "R8");
    drain();

    // R6: ride into both rails
    doReset();
    for (int i = 0; i < 300; i++) step(0, 1, "R6");
    for (int i = 0; i < 4; i++) step(1, 1, "R6");
    for (int i = 0; i < 560; i++) step(1, 0, "R6");
    drain();
    check(delayCode == 8'd0, "R6 floor", delayCode, 0);

    // Closed loop: line delay = code * 80 ps against an 8000 ps period
    doReset();
    for (int i = 0; i < 200; i++) begin
      int dly;
      @(posedge clk); #1;
      dly = int'(delayCode) * 80;
      step(dly > 8040, dly < 7960, "R7 loop");
    end
    drain();
    check(delayCode == 8'd100, "R7 loop settle", delayCode, 100);
    check(lockFlag == 1'b1, "R7 loop lock", lockFlag, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule